// File: doc/BRIEF.md
# Host-Driven Gate Line Sequencer

This block watches the writes a host makes to the command and data ports of a slave peripheral and drives a single gate output line by itself, without the internal processor having to act. The processor arms it once with a one-cycle enable strobe. After that it stays armed until reset. While armed, the block recognises a write-output-port command byte followed by a data byte. It copies one chosen bit of that data byte onto the gate line. An optional trailing close command byte may follow the pair.

For every host write, the block also reports whether the peripheral's normal input-buffer-full flag must stay low, because the block has consumed the byte itself. It reports this with a one-cycle suppress pulse. A write that produces no pulse is handled as normal, and the flag is raised. Host writes take effect on the trailing (rising) edge of the active-low write strobe, and only when chip select was active while the strobe was low.

Top module: `hostgate_seq`

## Requirements
- R1: During and right after reset, `gate_o` is 0 and `ibf_suppress_o` is 0.
- R2: Before the block is armed, no host write produces a suppress pulse and `gate_o` stays 0, even for the open command D1h followed by data.
- R3: A one-cycle high on `arm_i` arms the block. It stays armed through any number of host writes, and only reset disarms it.
- R4: While armed, a command write (`cmd_sel_i`=1) of the open code D1h produces a suppress pulse, opens a sequence and leaves `gate_o` unchanged.
- R5: While armed, a data write (`cmd_sel_i`=0) that follows an open command produces a suppress pulse and loads data bit 1 onto `gate_o`. All other data bits are ignored.
- R6: A close command FFh directly after a completed open/data pair produces a suppress pulse and leaves `gate_o` unchanged. An FFh at any other time produces no pulse.
- R7: Two open commands in a row followed by data form a valid sequence: every write of it is suppressed, and the data bit is applied.
- R8: A command other than D1h produces no pulse and cancels an open sequence. A data write after it produces no pulse and leaves `gate_o` unchanged.
- R9: A data write that does not follow an open command produces no pulse and leaves `gate_o` unchanged.
- R10: A write made while `cs_n_i` is high is ignored. It produces no pulse and does not open a sequence.
- R11: A write takes effect only on the rising edge of `wr_n_i`. While the strobe is held low, `gate_o` does not change.
- R12: Each suppressed write produces exactly one suppress pulse, one clock wide, in the cycle after the strobe edge is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; disarms the block |
| arm_i | input | 1 | One-cycle enable strobe from the internal processor |
| wr_n_i | input | 1 | Host write strobe, active low, acts on its rising edge |
| cs_n_i | input | 1 | Host chip select, active low |
| cmd_sel_i | input | 1 | 1 = command port, 0 = data port |
| data_i | input | DATA_W | Host data bus |
| gate_o | output | 1 | Gate line level |
| ibf_suppress_o | output | 1 | One-cycle pulse: keep the input-buffer-full flag low for this write |

## Verification
The checker enforces several rules on every cycle. The gate line stays at 0 while the block is disarmed, and it changes only in the cycle after an armed data-port event. Once armed, the block stays armed. A suppress pulse needs both a preceding strobe event and the armed state, and it never lasts two cycles. The bench scenarios cover what depends on ordering and values. These include the open/data/close sequences, the doubled open command, and cancellation by foreign commands. They also cover the mis-timed close code, the ignored data bits, unselected writes, the hold while the strobe is low, and disarming by reset.

// File: rtl/hg_pkg.sv
package hg_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE       = 2'd0,
      SQ_WAIT_DATA  = 2'd1,
      SQ_WAIT_CLOSE = 2'd2
   } seq_state_t;
endpackage

// File: rtl/hg_wr_capture.sv
module hg_wr_capture #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_n_i,
   input  logic              cs_n_i,
   input  logic              cmd_sel_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              evt_o,
   output logic              evt_cmd_o,
   output logic [DATA_W-1:0] evt_data_o
);
   logic wr_n_q;
   logic cs_lat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_n_q     <= 1'b1;
         cs_lat     <= 1'b0;
         evt_cmd_o  <= 1'b0;
         evt_data_o <= '0;
      end else begin
         wr_n_q <= wr_n_i;
         if (!wr_n_i) begin
            cs_lat     <= !cs_n_i;
            evt_cmd_o  <= cmd_sel_i;
            evt_data_o <= data_i;
         end
      end
   end

   // trailing edge of the strobe, qualified by the select seen while low
   assign evt_o = wr_n_i && !wr_n_q && cs_lat;
endmodule

// File: rtl/hg_seq_fsm.sv
module hg_seq_fsm
   import hg_pkg::*;
#(
   parameter int              DATA_W    = 8,
   parameter logic [DATA_W-1:0] CMD_OPEN  = 'hD1,
   parameter logic [DATA_W-1:0] CMD_CLOSE = 'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              armed_i,
   input  logic              evt_i,
   input  logic              evt_cmd_i,
   input  logic [DATA_W-1:0] evt_data_i,
   output logic              load_o,
   output logic              consume_o
);
   seq_state_t state_q, state_d;

   always_comb begin
      state_d   = state_q;
      load_o    = 1'b0;
      consume_o = 1'b0;
      if (!armed_i) begin
         state_d = SQ_IDLE;
      end else if (evt_i) begin
         if (evt_cmd_i) begin
            if (evt_data_i == CMD_OPEN) begin
               state_d   = SQ_WAIT_DATA;
               consume_o = 1'b1;
            end else if (evt_data_i == CMD_CLOSE && state_q == SQ_WAIT_CLOSE) begin
               state_d   = SQ_IDLE;
               consume_o = 1'b1;
            end else begin
               state_d = SQ_IDLE;
            end
         end else begin
            if (state_q == SQ_WAIT_DATA) begin
               state_d   = SQ_WAIT_CLOSE;
               load_o    = 1'b1;
               consume_o = 1'b1;
            end else begin
               state_d = SQ_IDLE;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SQ_IDLE;
      else        state_q <= state_d;
   end
endmodule

// File: rtl/hg_gate_reg.sv
module hg_gate_reg #(
   parameter bit RESET_GATE   = 1'b0,
   parameter bit REG_SUPPRESS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic bit_i,
   input  logic consume_i,
   output logic gate_o,
   output logic suppress_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      gate_o <= RESET_GATE;
      else if (load_i) gate_o <= bit_i;
   end

   generate
      if (REG_SUPPRESS) begin : g_reg_sup
         logic sup_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sup_q <= 1'b0;
            else        sup_q <= consume_i;
         end
         assign suppress_o = sup_q;
      end else begin : g_comb_sup
         assign suppress_o = consume_i;
      end
   endgenerate
endmodule

// File: rtl/hostgate_seq.sv
module hostgate_seq #(
   parameter int              DATA_W       = 8,
   parameter int              GATE_BIT     = 1,
   parameter logic [DATA_W-1:0] CMD_OPEN     = 'hD1,
   parameter logic [DATA_W-1:0] CMD_CLOSE    = 'hFF,
   parameter bit              RESET_GATE   = 1'b0,
   parameter bit              REG_SUPPRESS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm_i,
   input  logic              wr_n_i,
   input  logic              cs_n_i,
   input  logic              cmd_sel_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              gate_o,
   output logic              ibf_suppress_o
);
   localparam int GB = (GATE_BIT < DATA_W) ? GATE_BIT : 0;

   generate
      if (DATA_W < 2)
         $error("hostgate_seq: DATA_W must be at least 2");
      if (GATE_BIT >= DATA_W || GATE_BIT < 0)
         $error("hostgate_seq: GATE_BIT outside the data bus");
      if (CMD_OPEN == CMD_CLOSE)
         $error("hostgate_seq: open and close codes must differ");
   endgenerate

   logic              armed_q;
   logic              wr_evt;
   logic              evt_cmd;
   logic [DATA_W-1:0] evt_data;
   logic              load;
   logic              consume;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     armed_q <= 1'b0;
      else if (arm_i) armed_q <= 1'b1;
   end

   hg_wr_capture #(.DATA_W(DATA_W)) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_n_i     (wr_n_i),
      .cs_n_i     (cs_n_i),
      .cmd_sel_i  (cmd_sel_i),
      .data_i     (data_i),
      .evt_o      (wr_evt),
      .evt_cmd_o  (evt_cmd),
      .evt_data_o (evt_data)
   );

   hg_seq_fsm #(
      .DATA_W    (DATA_W),
      .CMD_OPEN  (CMD_OPEN),
      .CMD_CLOSE (CMD_CLOSE)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .armed_i    (armed_q),
      .evt_i      (wr_evt),
      .evt_cmd_i  (evt_cmd),
      .evt_data_i (evt_data),
      .load_o     (load),
      .consume_o  (consume)
   );

   hg_gate_reg #(
      .RESET_GATE   (RESET_GATE),
      .REG_SUPPRESS (REG_SUPPRESS)
   ) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .bit_i      (evt_data[GB]),
      .consume_i  (consume),
      .gate_o     (gate_o),
      .suppress_o (ibf_suppress_o)
   );
endmodule

// File: rtl/hg_checker.sv
module hg_checker #(
   parameter bit RESET_GATE = 1'b0,
   parameter bit REG_SUP    = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic armed_q,
   input logic wr_evt,
   input logic evt_cmd,
   input logic gate_o,
   input logic ibf_suppress_o
);
   AST_GATE_RESET_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_q |-> gate_o == RESET_GATE); // R2

   AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |=> armed_q); // R3

   AST_GATE_ONLY_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_o != $past(gate_o)) |-> $past(wr_evt && !evt_cmd && armed_q)); // R11

   AST_SUPPRESS_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      ibf_suppress_o |-> (REG_SUP ? ($past(wr_evt) && $past(armed_q)) : (wr_evt && armed_q))); // R12

   AST_SUPPRESS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      ibf_suppress_o |=> !ibf_suppress_o); // R12
endmodule

bind hostgate_seq hg_checker #(
   .RESET_GATE (RESET_GATE),
   .REG_SUP    (REG_SUPPRESS)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .armed_q        (armed_q),
   .wr_evt         (wr_evt),
   .evt_cmd        (evt_cmd),
   .gate_o         (gate_o),
   .ibf_suppress_o (ibf_suppress_o)
);

// File: tb/hostgate_seq_bench.sv
`timescale 1ns/1ps
module hostgate_seq_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       arm_i = 1'b0;
   logic       wr_n_i = 1'b1;
   logic       cs_n_i = 1'b1;
   logic       cmd_sel_i = 1'b0;
   logic [7:0] data_i = 8'h00;
   logic       gate_o;
   logic       ibf_suppress_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   hostgate_seq u_hostgate_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .arm_i          (arm_i),
      .wr_n_i         (wr_n_i),
      .cs_n_i         (cs_n_i),
      .cmd_sel_i      (cmd_sel_i),
      .data_i         (data_i),
      .gate_o         (gate_o),
      .ibf_suppress_o (ibf_suppress_o)
   );

   task automatic check(input string req, input string what, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
      end
   endtask

   // one host write; hold the strobe low for HOLD cycles, then check results
   task automatic host_write(input logic is_cmd, input logic [7:0] val, input logic selected,
                             input logic exp_sup, input logic exp_gate, input string req);
      logic gate_before;
      @(negedge clk);
      gate_before = gate_o;
      cs_n_i    = !selected;
      cmd_sel_i = is_cmd;
      data_i    = val;
      wr_n_i    = 1'b0;
      repeat (3) @(negedge clk);
      wr_n_i = 1'b1;
      @(negedge clk);
      check(req, "suppress after edge", ibf_suppress_o, exp_sup);
      check(req, "gate after write", gate_o, exp_gate);
      @(negedge clk);
      if (exp_sup) check("R12", "suppress one cycle wide", ibf_suppress_o, 1'b0);
      cs_n_i = 1'b1;
      if (is_cmd) check(req, "command leaves gate", gate_o, gate_before);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1", "gate in reset", gate_o, 1'b0);
      check("R1", "suppress in reset", ibf_suppress_o, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "gate after reset", gate_o, 1'b0);
   endtask

   task automatic do_arm();
      @(negedge clk);
      arm_i = 1'b1;
      @(negedge clk);
      arm_i = 1'b0;
   endtask

   task automatic t_unarmed();
      host_write(1'b1, 8'hD1, 1'b1, 1'b0, 1'b0, "R2");
      host_write(1'b0, 8'hFF, 1'b1, 1'b0, 1'b0, "R2");
      host_write(1'b1, 8'hFF, 1'b1, 1'b0, 1'b0, "R2");
   endtask

   task automatic t_set_clear();
      host_write(1'b1, 8'hD1, 1'b1, 1'b1, 1'b0, "R4");
      host_write(1'b0, 8'h02, 1'b1, 1'b1, 1'b1, "R5");
      host_write(1'b1, 8'hFF, 1'b1, 1'b1, 1'b1, "R6");
      host_write(1'b1, 8'hD1, 1'b1, 1'b1, 1'b1, "R4");
      host_write(1'b0, 8'hFD, 1'b1, 1'b1, 1'b0, "R5");  // bit1 clear, rest set
      host_write(1'b1, 8'hFF, 1'b1, 1'b1, 1'b0, "R6");
   endtask

   task automatic t_double_open();
      host_write(1'b1, 8'hD1, 1'b1, 1'b1, 1'b0, "R7");
      host_write(1'b1, 8'hD1, 1'b1, 1'b1, 1'b0, "R7");
      host_write(1'b0, 8'h02, 1'b1, 1'b1, 1'b1, "R7");
      host_write(1'b1, 8'hFF, 1'b1, 1'b1, 1'b1, "R6");
   endtask

   task automatic t_misplaced_close();
      host_write(1'b1, 8'hFF, 1'b1, 1'b0, 1'b1, "R6");  // idle
      host_write(1'b1, 8'hD1, 1'b1, 1'b1, 1'b1, "R4");
      host_write(1'b1, 8'hFF, 1'b1, 1'b0, 1'b1, "R6");  // in place of data
      host_write(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, "R8");
   endtask

   task automatic t_foreign_cmd();
      host_write(1'b1, 8'hD1, 1'b1, 1'b1, 1'b1, "R4");
      host_write(1'b1, 8'hAA, 1'b1, 1'b0, 1'b1, "R8");
      host_write(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, "R8");
   endtask

   task automatic t_stray_data();
      host_write(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, "R9");
   endtask

   task automatic t_unselected();
      host_write(1'b1, 8'hD1, 1'b0, 1'b0, 1'b1, "R10");
      host_write(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, "R10");
   endtask

   task automatic t_trailing_edge();
      host_write(1'b1, 8'hD1, 1'b1, 1'b1, 1'b1, "R3");
      @(negedge clk);
      cs_n_i = 1'b0; cmd_sel_i = 1'b0; data_i = 8'h00; wr_n_i = 1'b0;
      repeat (4) begin
         @(negedge clk);
         check("R11", "gate held while strobe low", gate_o, 1'b1);
         check("R11", "no suppress while strobe low", ibf_suppress_o, 1'b0);
      end
      wr_n_i = 1'b1;
      @(negedge clk);
      check("R11", "suppress at trailing edge", ibf_suppress_o, 1'b1);
      check("R11", "gate after trailing edge", gate_o, 1'b0);
      @(negedge clk);
      cs_n_i = 1'b1;
      check("R12", "suppress one cycle wide", ibf_suppress_o, 1'b0);
   endtask

   task automatic t_reset_disarms();
      do_reset();
      host_write(1'b1, 8'hD1, 1'b1, 1'b0, 1'b0, "R3");
      host_write(1'b0, 8'h02, 1'b1, 1'b0, 1'b0, "R3");
   endtask

   initial begin
      do_reset();
      t_unarmed();
      do_arm();
      t_set_clear();
      t_double_open();
      t_misplaced_close();
      t_foreign_cmd();
      t_stray_data();
      t_unselected();
      t_trailing_edge();
      t_reset_disarms();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end
endmodule